// File: doc/BRIEF.md
# Multi-Mode Display Host Interface

This block is the host-facing front end of a display controller. One shared set of pins carries command and data bytes from a host processor. A static 3-bit strap chooses how those pins are read: as a parallel bus with a separate write strobe, as a parallel bus with an enable and a read/write select, as a four-wire serial link with a separate data/command pin, or as a three-wire serial link that carries the data/command flag in the frame itself. Whichever bus is active, each received byte leaves the block on one internal port. That port carries the byte, a flag that separates display data from commands, and a valid pulse that lasts one clock.

Every host pin passes through a synchroniser before any edge is detected, so the host may run at any speed slower than the system clock. On the parallel buses a host read puts a status byte on the data pins through a separate drive enable for the pad's tri-state buffer. The status byte reports the decoded bus mode. The two-wire addressed-bus strap is decoded and reported, but it delivers no bytes.

Top module: `dhi_host_if`

## Requirements
- R1: `mode_o` reports the strap `mode_sel` as follows: 3'b110 gives 1 (strobe parallel), 3'b100 gives 2 (enable parallel), 3'b000 gives 3 (four-wire serial), 3'b001 gives 4 (three-wire serial), 3'b010 gives 5 (addressed two-wire), and any other value gives 0 (idle). Modes 5 and 0 never deliver a byte.
- R2: In mode 1 with `host_cs_n` low, a rising edge of `host_wr` delivers the byte on `bus_i` as one byte. `out_is_data` equals `host_dc`, where 1 means display data and 0 means command.
- R3: In mode 2 with `host_cs_n` low and `host_wr` low, a falling edge of the active-high enable `host_rd` delivers `bus_i` and `host_dc`. A falling enable while `host_wr` is high delivers nothing.
- R4: In mode 3, `bus_i[0]` is the serial clock and `bus_i[1]` is the data input. Eight bits are taken MSB first on rising clock edges. `out_is_data` is the value of `host_dc` at the eighth edge.
- R5: In mode 4 a frame is nine bits taken on rising clock edges. The first bit is the flag (1 means data) and the next eight bits are the byte, MSB first.
- R6: While `host_cs_n` is high no byte is delivered. In the serial modes, a high `host_cs_n` discards any partly received frame.
- R7: In mode 1, `host_cs_n` low with `host_rd` low sets `bus_oe` high. In mode 2, `host_cs_n` low with `host_wr` high and `host_rd` high sets `bus_oe` high. While `bus_oe` is high, `bus_o` is `mode_o` zero-extended.
- R8: In modes 0, 3, 4 and 5, `bus_oe` stays low whatever the host pins do.
- R9: `out_valid` is high for exactly one clock per delivered byte.
- R10: While `rst_n` is low, `out_valid` and `out_byte` are zero. A serial frame cut off by reset is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, level sensitive |
| mode_sel | input | 3 | Static bus-mode strap |
| host_cs_n | input | 1 | Active-low chip select |
| host_dc | input | 1 | Data (1) or command (0) select |
| host_wr | input | 1 | Write strobe (mode 1) or read/write select (mode 2) |
| host_rd | input | 1 | Read strobe (mode 1) or enable (mode 2) |
| bus_i | input | DW | Data pins in; bits 0 and 1 carry the serial clock and data |
| bus_o | output | DW | Status byte driven on reads |
| bus_oe | output | 1 | Drive enable for the data pad buffers |
| mode_o | output | 3 | Decoded bus mode |
| out_valid | output | 1 | One-clock strobe for each received byte |
| out_byte | output | DW | Received byte |
| out_is_data | output | 1 | 1 means display data, 0 means command |

## Verification
The assertions assume that the strap changes only while the bus is idle, and that every host strobe and serial clock level is held for at least two system clocks. The one-clock pulse check and the chip-select check depend on that spacing. The stimulus holds each strobe and clock level for three or four clocks. It keeps data, flag and select steady around every edge, and it changes `mode_sel` only after several clocks with chip select high.

// File: rtl/dhi_pkg.sv
package dhi_pkg;

   typedef enum logic [2:0] {
      MODE_IDLE = 3'd0,
      MODE_P80  = 3'd1,
      MODE_P68  = 3'd2,
      MODE_SPI4 = 3'd3,
      MODE_SPI3 = 3'd4,
      MODE_I2C  = 3'd5
   } dhi_mode_e;

   // strap decode: the bit patterns are fixed by board wiring
   function automatic dhi_mode_e dhi_decode(input logic [2:0] strap);
      case (strap)
         3'b110:  return MODE_P80;
         3'b100:  return MODE_P68;
         3'b000:  return MODE_SPI4;
         3'b001:  return MODE_SPI3;
         3'b010:  return MODE_I2C;
         default: return MODE_IDLE;
      endcase
   endfunction

endpackage

// File: rtl/dhi_sync.sv
module dhi_sync #(
   parameter int          W       = 1,
   parameter int          STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);
   logic [W-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
      end else begin
         stg[0] <= din;
         for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      end
   end

   assign dout = stg[STAGES-1];
endmodule

// File: rtl/dhi_par_rx.sv
module dhi_par_rx
   import dhi_pkg::*;
#(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  dhi_mode_e     mode,
   input  logic          cs_n_s,
   input  logic          dc_s,
   input  logic          wr_s,
   input  logic          rd_s,
   input  logic [DW-1:0] bus_s,
   output logic          vld,
   output logic [DW-1:0] byte_o,
   output logic          flag_o
);
   logic wr_q, rd_q;
   logic wr_rise, en_fall, hit;

   assign wr_rise = wr_s & ~wr_q;
   assign en_fall = ~rd_s & rd_q;
   assign hit     = ~cs_n_s &
                    (((mode == MODE_P80) & wr_rise) |
                     ((mode == MODE_P68) & en_fall & ~wr_s));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_q   <= 1'b1;
         rd_q   <= 1'b1;
         vld    <= 1'b0;
         byte_o <= '0;
         flag_o <= 1'b0;
      end else begin
         wr_q <= wr_s;
         rd_q <= rd_s;
         vld  <= hit;
         if (hit) begin
            byte_o <= bus_s;
            flag_o <= dc_s;
         end
      end
   end
endmodule

// File: rtl/dhi_ser_rx.sv
module dhi_ser_rx
   import dhi_pkg::*;
#(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  dhi_mode_e     mode,
   input  logic          cs_n_s,
   input  logic          dc_s,
   input  logic          sck_s,
   input  logic          sdi_s,
   output logic          vld,
   output logic [DW-1:0] byte_o,
   output logic          flag_o
);
   localparam int CW = $clog2(DW + 1);

   logic          sck_q, sck_rise;
   logic          is4, is3;
   logic [CW-1:0] cnt, last;
   logic [DW-1:0] sh;
   logic          pend_flag;

   assign sck_rise = sck_s & ~sck_q;
   assign is4      = (mode == MODE_SPI4);
   assign is3      = (mode == MODE_SPI3);
   assign last     = is3 ? CW'(DW) : CW'(DW - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_q     <= 1'b0;
         cnt       <= '0;
         sh        <= '0;
         pend_flag <= 1'b0;
         vld       <= 1'b0;
         byte_o    <= '0;
         flag_o    <= 1'b0;
      end else begin
         sck_q <= sck_s;
         vld   <= 1'b0;
         if (cs_n_s || !(is3 || is4)) begin
            cnt <= '0;
         end else if (sck_rise) begin
            if (is3 && cnt == '0) begin
               pend_flag <= sdi_s;
               cnt       <= cnt + 1'b1;
            end else begin
               sh <= {sh[DW-2:0], sdi_s};
               if (cnt == last) begin
                  vld    <= 1'b1;
                  byte_o <= {sh[DW-2:0], sdi_s};
                  flag_o <= is4 ? dc_s : pend_flag;
                  cnt    <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
         end
      end
   end
endmodule

// File: rtl/dhi_host_if.sv
module dhi_host_if
   import dhi_pkg::*;
#(
   parameter int DW          = 8,
   parameter int SYNC_STAGES = 2,
   parameter bit READ_EN     = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [2:0]    mode_sel,
   input  logic          host_cs_n,
   input  logic          host_dc,
   input  logic          host_wr,
   input  logic          host_rd,
   input  logic [DW-1:0] bus_i,
   output logic [DW-1:0] bus_o,
   output logic          bus_oe,
   output logic [2:0]    mode_o,
   output logic          out_valid,
   output logic [DW-1:0] out_byte,
   output logic          out_is_data
);
   localparam int SW = DW + 4;
   localparam logic [SW-1:0] SYNC_RST = {1'b1, 1'b0, 1'b1, 1'b1, {DW{1'b0}}};

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (DW < 4) begin : g_bad_dw
      $error("DW must be at least 4");
   end

   dhi_mode_e     mode;
   logic [SW-1:0] sync_q;
   logic          cs_n_s, dc_s, wr_s, rd_s;
   logic [DW-1:0] bus_s;
   logic          p_vld, s_vld, p_flag, s_flag;
   logic [DW-1:0] p_byte, s_byte;

   assign mode   = dhi_decode(mode_sel);
   assign mode_o = mode;

   dhi_sync #(.W(SW), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  ({host_cs_n, host_dc, host_wr, host_rd, bus_i}),
      .dout (sync_q)
   );
   assign {cs_n_s, dc_s, wr_s, rd_s, bus_s} = sync_q;

   dhi_par_rx #(.DW(DW)) u_par (
      .clk   (clk),
      .rst_n (rst_n),
      .mode  (mode),
      .cs_n_s(cs_n_s),
      .dc_s  (dc_s),
      .wr_s  (wr_s),
      .rd_s  (rd_s),
      .bus_s (bus_s),
      .vld   (p_vld),
      .byte_o(p_byte),
      .flag_o(p_flag)
   );

   dhi_ser_rx #(.DW(DW)) u_ser (
      .clk   (clk),
      .rst_n (rst_n),
      .mode  (mode),
      .cs_n_s(cs_n_s),
      .dc_s  (dc_s),
      .sck_s (bus_s[0]),
      .sdi_s (bus_s[1]),
      .vld   (s_vld),
      .byte_o(s_byte),
      .flag_o(s_flag)
   );

   // parallel and serial receivers never pulse together: modes exclusive
   assign out_valid   = p_vld | s_vld;
   assign out_byte    = s_vld ? s_byte : (p_vld ? p_byte : '0);
   assign out_is_data = s_vld ? s_flag : (p_vld & p_flag);

   if (READ_EN) begin : g_read
      assign bus_oe = ~host_cs_n &
                      (((mode == MODE_P80) & ~host_rd) |
                       ((mode == MODE_P68) & host_wr & host_rd));
      assign bus_o  = {{(DW-3){1'b0}}, mode_o};
   end else begin : g_no_read
      assign bus_oe = 1'b0;
      assign bus_o  = '0;
   end
endmodule

// File: rtl/dhi_host_if_chk.sv
module dhi_host_if_chk #(
   parameter int DW = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          cs_s,
   input logic          host_cs_n,
   input logic [2:0]    mode_o,
   input logic          bus_oe,
   input logic [DW-1:0] bus_o,
   input logic          out_valid,
   input logic [DW-1:0] out_byte
);
   // one clock per byte
   assert_one_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |=> !out_valid);

   // synchronised deselect blocks delivery on the next clock
   assert_cs_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
      cs_s |=> !out_valid);

   assert_quiet_modes_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o == 3'd0 || mode_o == 3'd5) |-> !out_valid);

   assert_status_R7: assert property (@(posedge clk) disable iff (!rst_n)
      bus_oe |-> (!host_cs_n && bus_o == {{(DW-3){1'b0}}, mode_o}));

   assert_serial_hiz_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o != 3'd1 && mode_o != 3'd2) |-> !bus_oe);

   always @(posedge clk) begin
      if (!rst_n) begin
         assert_reset_quiet_R10: assert (!out_valid && out_byte == '0);
      end
   end
endmodule

bind dhi_host_if dhi_host_if_chk #(.DW(DW)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cs_s     (cs_n_s),
   .host_cs_n(host_cs_n),
   .mode_o   (mode_o),
   .bus_oe   (bus_oe),
   .bus_o    (bus_o),
   .out_valid(out_valid),
   .out_byte (out_byte)
);

// File: tb/dhi_host_if_tb.sv
`timescale 1ns/1ps
module dhi_host_if_tb;
   localparam int DW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [2:0]    mode_sel = 3'b110;
   logic          host_cs_n = 1'b1, host_dc = 1'b0, host_wr = 1'b1, host_rd = 1'b1;
   logic [DW-1:0] bus_i = '0;
   logic [DW-1:0] bus_o, out_byte;
   logic          bus_oe, out_valid, out_is_data;
   logic [2:0]    mode_o;

   int n_chk = 0, n_fail = 0;
   int got_n = 0;
   logic [DW-1:0] got_b = '0;
   logic          got_f = 1'b0;
   bit            done = 0;

   always #2.5 clk = ~clk;

   dhi_host_if u_dut (
      .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .host_cs_n(host_cs_n),
      .host_dc(host_dc), .host_wr(host_wr), .host_rd(host_rd), .bus_i(bus_i),
      .bus_o(bus_o), .bus_oe(bus_oe), .mode_o(mode_o), .out_valid(out_valid),
      .out_byte(out_byte), .out_is_data(out_is_data)
   );

   always @(negedge clk) begin
      if (out_valid) begin
         got_n = got_n + 1;
         got_b = out_byte;
         got_f = out_is_data;
      end
   end

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic p80_write(input logic dc, input logic [7:0] b, input logic csl);
      host_cs_n = ~csl; host_dc = dc; bus_i = b; host_rd = 1'b1; host_wr = 1'b0;
      cyc(4); host_wr = 1'b1; cyc(4); host_cs_n = 1'b1; cyc(2);
   endtask

   task automatic p68_write(input logic dc, input logic [7:0] b, input logic csl);
      host_rd = 1'b0; host_wr = 1'b0; cyc(2);
      host_cs_n = ~csl; host_dc = dc; bus_i = b; cyc(2);
      host_rd = 1'b1; cyc(4); host_rd = 1'b0; cyc(4); host_cs_n = 1'b1; cyc(2);
   endtask

   // sends n bits MSB first on bus_i[1], clock on bus_i[0]; host_dc = dc only on the last bit
   task automatic ser_bits(input logic [15:0] bits, input int n, input logic dc);
      for (int i = n - 1; i >= 0; i--) begin
         bus_i[1] = bits[i];
         host_dc  = (i == 0) ? dc : ~dc;
         cyc(3); bus_i[0] = 1'b1; cyc(3); bus_i[0] = 1'b0;
      end
      cyc(4);
   endtask

   // {cs_low, mode[2:0], dc, byte}
   localparam logic [12:0] VEC [14] = '{
      {1'b1, 3'b110, 1'b1, 8'hA5}, {1'b1, 3'b110, 1'b0, 8'h3C}, {1'b0, 3'b110, 1'b1, 8'hFF},
      {1'b1, 3'b100, 1'b1, 8'h5A}, {1'b1, 3'b100, 1'b0, 8'h81}, {1'b0, 3'b100, 1'b0, 8'h77},
      {1'b1, 3'b000, 1'b1, 8'hC3}, {1'b1, 3'b000, 1'b0, 8'h01}, {1'b0, 3'b000, 1'b1, 8'hEE},
      {1'b1, 3'b001, 1'b1, 8'h96}, {1'b1, 3'b001, 1'b0, 8'h80}, {1'b0, 3'b001, 1'b0, 8'h42},
      {1'b1, 3'b010, 1'b1, 8'h99}, {1'b1, 3'b011, 1'b1, 8'h11}
   };

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual 0x0 expected 0x1");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      cyc(3);
      // R10 reset state
      check(!out_valid && out_byte == 8'h00 && !bus_oe, "R10 reset state",
            {out_valid, out_byte}, 0);
      rst_n = 1'b1; cyc(4);

      // R1 strap decode
      for (int m = 0; m < 8; m++) begin
         logic [2:0] exp_m;
         mode_sel = 3'(m); cyc(1);
         case (3'(m))
            3'b110: exp_m = 3'd1; 3'b100: exp_m = 3'd2; 3'b000: exp_m = 3'd3;
            3'b001: exp_m = 3'd4; 3'b010: exp_m = 3'd5; default: exp_m = 3'd0;
         endcase
         check(mode_o == exp_m, "R1 mode decode", mode_o, exp_m);
      end

      // vector table walk
      for (int v = 0; v < 14; v++) begin
         logic       csl, dc, deliver;
         logic [2:0] m;
         logic [7:0] b;
         string      req;
         {csl, m, dc, b} = VEC[v];
         host_cs_n = 1'b1; host_wr = 1'b1; host_rd = 1'b1; bus_i = '0;
         mode_sel = m; cyc(4);
         got_n = 0;
         case (m)
            3'b110: begin p80_write(dc, b, csl); req = "R2 strobe write"; end
            3'b100: begin p68_write(dc, b, csl); req = "R3 enable write"; end
            3'b000: begin host_cs_n = ~csl; cyc(3); ser_bits({8'h00, b}, 8, dc);
                          host_cs_n = 1'b1; req = "R4 four-wire"; end
            3'b001: begin host_cs_n = ~csl; cyc(3); ser_bits({7'h00, dc, b}, 9, 1'b0);
                          host_cs_n = 1'b1; req = "R5 three-wire"; end
            default: begin p80_write(dc, b, csl); host_cs_n = 1'b0; cyc(3);
                          ser_bits({8'h00, b}, 8, dc); host_cs_n = 1'b1;
                          req = "R1 quiet mode"; end
         endcase
         cyc(6);
         deliver = csl && (m == 3'b110 || m == 3'b100 || m == 3'b000 || m == 3'b001);
         if (!csl) req = "R6 deselected";
         check(got_n == (deliver ? 1 : 0), req, got_n, deliver ? 1 : 0);
         if (deliver) begin
            check(got_b == b, req, got_b, b);
            check(got_f == dc, req, got_f, dc);
         end
      end

      // R7 strobe-parallel read
      host_cs_n = 1'b1; host_wr = 1'b1; host_rd = 1'b1; bus_i = '0;
      mode_sel = 3'b110; cyc(4);
      host_cs_n = 1'b0; host_rd = 1'b0; cyc(1);
      check(bus_oe && bus_o == 8'h01, "R7 strobe read", {bus_oe, bus_o}, 9'h101);
      host_rd = 1'b1; cyc(1);
      check(!bus_oe, "R7 read release", bus_oe, 0);
      host_cs_n = 1'b1; cyc(4);

      // R7 enable-parallel read, R3 read cycle delivers nothing
      mode_sel = 3'b100; host_rd = 1'b0; cyc(4); got_n = 0;
      host_cs_n = 1'b0; host_wr = 1'b1; cyc(2); host_rd = 1'b1; cyc(1);
      check(bus_oe && bus_o == 8'h02, "R7 enable read", {bus_oe, bus_o}, 9'h102);
      cyc(3); host_rd = 1'b0; cyc(6);
      check(got_n == 0, "R3 read no byte", got_n, 0);
      host_cs_n = 1'b1; cyc(4);

      // R8 serial mode never drives
      mode_sel = 3'b000; host_rd = 1'b0; host_wr = 1'b1; cyc(2); host_cs_n = 1'b0; cyc(2);
      check(!bus_oe, "R8 serial no drive", bus_oe, 0);
      host_cs_n = 1'b1; host_rd = 1'b1; cyc(4);

      // R6 partial frame discarded by deselect
      got_n = 0; host_cs_n = 1'b0; cyc(3);
      ser_bits(16'h0005, 3, 1'b0);
      host_cs_n = 1'b1; cyc(4); host_cs_n = 1'b0; cyc(3);
      ser_bits(16'h006B, 8, 1'b1);
      host_cs_n = 1'b1; cyc(6);
      check(got_n == 1 && got_b == 8'h6B && got_f, "R6 partial discard",
            {got_n[7:0], got_b}, 16'h016B);

      // R10 reset mid-frame in three-wire mode
      mode_sel = 3'b001; cyc(4); got_n = 0;
      host_cs_n = 1'b0; cyc(3);
      ser_bits(16'h0015, 5, 1'b0);
      rst_n = 1'b0; cyc(2);
      check(!out_valid && out_byte == 8'h00, "R10 reset output", out_byte, 0);
      rst_n = 1'b1; cyc(4);
      ser_bits(16'h0035, 9, 1'b1);
      host_cs_n = 1'b1; cyc(6);
      check(got_n == 1 && got_b == 8'h35 && !got_f, "R10 frame after reset",
            {got_n[7:0], got_b}, 16'h0135);

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule